// File: doc/BRIEF.md
# Single-line MESI L1 coherence controller with eviction notify

This block tracks one line of a private L1 cache under a directory-based MESI protocol. It takes processor requests (load, instruction fetch, store, replacement) and messages from the coherence network (invalidate, forwarded exclusive request, shared or exclusive fill data, acknowledge). It answers with registered network messages: read and ownership requests, invalidation acks, data to L2, data to a requestor and a dirty writeback. A processor request that the line cannot serve is left unaccepted (`cpu_ready_o` low). The requester keeps it at the head of its queue and presents it again later.

Whenever the line leaves S, E or M because of a replacement, an invalidate or a forwarded exclusive request, the block raises a one-cycle notify with the line address toward the processor's load/store queue. The queue can then squash speculative loads to that line. A static enable input gates the notify. Network messages have priority over processor requests in any cycle.

Top module: `l1_line_ctrl`

## Requirements
- R1: After reset the line is invalid. `msg_valid_o` and `evict_valid_o` are low, and `cpu_ready_o` is high while no network message is offered.
- R2: Processor op codes are load=0, ifetch=1, store=2, replace=3. Out message codes are GETS=0, GETX=1, INV_ACK=2, DATA_L2=3, DATA_REQ=4, PUTX=5. In I, a load or ifetch captures `cpu_addr_i` and sends GETS with that address. A store captures the address and its data and sends GETX. A replace is accepted with no message. Every output message appears one cycle after its trigger.
- R3: Net codes are INV=0, FWD_GETX=1, DATA_S=2, DATA_E=3, ACK=4. While a read miss is pending, DATA_S fills to S and DATA_E fills to E, taking `net_data_i` as line data. A pending store miss completes on DATA_E and reaches M holding the store data. A store in S sends GETX and completes on ACK, reaching M with the store data.
- R4: In S, a replace sends no message and leaves the line invalid. An INV sends INV_ACK and leaves the line invalid.
- R5: In E, a store moves to M with no message. In E or M, a replace sends PUTX carrying the line data and waits for the writeback ACK.
- R6: In E, an INV sends INV_ACK and the line goes invalid. In M, an INV sends DATA_L2 carrying the line data and the line goes invalid.
- R7: In E or M, FWD_GETX sends DATA_REQ carrying the line data and the line goes invalid.
- R8: Each transition of R4 to R7 that leaves S, E or M raises `evict_valid_o` for exactly one cycle, with `evict_addr_o` equal to the line address. The pulse comes in the same cycle as that transition's message. It is raised only when `evict_en_i` is high.
- R9: `cpu_ready_o` is low whenever `net_valid_i` is high. It is also low in every transient state (miss pending, upgrade pending, writeback pending, writeback sink). A request that is not accepted has no effect.
- R10: While the writeback is pending, ACK makes the line invalid. FWD_GETX sends DATA_REQ and INV sends DATA_L2, both carrying the buffered writeback data, and either one moves the line to a sink state. In the sink, INV is answered with INV_ACK, and ACK makes the line invalid.
- R11: An INV during a pending read miss is answered with INV_ACK. The fill that follows leaves the line invalid, so the next load misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evict_en_i | input | 1 | Static enable for the eviction notify |
| cpu_valid_i | input | 1 | Processor request at queue head |
| cpu_op_i | input | 2 | Request op code |
| cpu_addr_i | input | AW | Request line address |
| cpu_wdata_i | input | DW | Store data |
| cpu_ready_o | output | 1 | Request accepted this cycle |
| net_valid_i | input | 1 | Network message present (always consumed) |
| net_type_i | input | 3 | Network message code |
| net_data_i | input | DW | Fill data |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_type_o | output | 3 | Outgoing message code |
| msg_addr_o | output | AW | Outgoing message line address |
| msg_data_o | output | DW | Outgoing message data |
| evict_valid_o | output | 1 | Eviction notify pulse |
| evict_addr_o | output | AW | Evicted line address |

## Verification
A processor replacement and a network invalidate can arrive in the same cycle while the line is valid, and both would evict the line. The bench offers both at once with the line in E. It expects the invalidate to win: INV_ACK is sent, a single notify pulse is raised, and `cpu_ready_o` is low, so the replace is recycled. The same collision is repeated during a pending writeback, where the invalidate must take the data from the writeback buffer.

// File: rtl/l1c_pkg.sv
package l1c_pkg;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_IFETCH = 2'd1, OP_STORE = 2'd2, OP_REPL = 2'd3} cpu_op_e;
  typedef enum logic [2:0] {NM_INV = 3'd0, NM_FWDX = 3'd1, NM_DATA_S = 3'd2, NM_DATA_E = 3'd3,
                            NM_ACK = 3'd4} net_msg_e;
  typedef enum logic [2:0] {OM_GETS = 3'd0, OM_GETX = 3'd1, OM_INV_ACK = 3'd2, OM_DATA_L2 = 3'd3,
                            OM_DATA_REQ = 3'd4, OM_PUTX = 3'd5} out_msg_e;
  typedef enum logic [3:0] {ST_I, ST_S, ST_E, ST_M, ST_IS, ST_IM, ST_SM, ST_IS_I, ST_M_I,
                            ST_SINK} line_st_e;
  typedef struct packed {
    logic     msg_vld;
    out_msg_e msg;
    logic     from_tbe;
    logic     evict;
    logic     cap_addr;
    logic     tbe_wdata;
    logic     tbe_line;
    logic     line_wdata;
    logic     line_net;
    logic     line_tbe;
  } act_t;
endpackage

// File: rtl/l1c_fsm.sv
module l1c_fsm
  import l1c_pkg::*;
(
  input  line_st_e   st_q,
  input  logic       cpu_valid_i,
  input  logic [1:0] cpu_op_i,
  input  logic       net_valid_i,
  input  logic [2:0] net_type_i,
  output line_st_e   st_d,
  output logic       cpu_ready_o,
  output act_t       act_o
);
  cpu_op_e  op;
  net_msg_e nm;
  logic     stable;

  assign op     = cpu_op_e'(cpu_op_i);
  assign nm     = net_msg_e'(net_type_i);
  assign stable = (st_q == ST_I) || (st_q == ST_S) || (st_q == ST_E) || (st_q == ST_M);
  assign cpu_ready_o = stable && !net_valid_i;

  always_comb begin
    st_d  = st_q;
    act_o = '0;
    if (net_valid_i) begin
      unique case (st_q)
        ST_I: if (nm == NM_INV) begin act_o.msg_vld = 1'b1; act_o.msg = OM_INV_ACK; end
        ST_S: if (nm == NM_INV) begin
          act_o.msg_vld = 1'b1; act_o.msg = OM_INV_ACK; act_o.evict = 1'b1; st_d = ST_I;
        end
        ST_E, ST_M: begin
          if (nm == NM_INV) begin
            act_o.msg_vld = 1'b1; act_o.evict = 1'b1; st_d = ST_I;
            act_o.msg = (st_q == ST_M) ? OM_DATA_L2 : OM_INV_ACK;
          end else if (nm == NM_FWDX) begin
            act_o.msg_vld = 1'b1; act_o.msg = OM_DATA_REQ; act_o.evict = 1'b1; st_d = ST_I;
          end
        end
        ST_IS: begin
          if (nm == NM_DATA_S) begin act_o.line_net = 1'b1; st_d = ST_S; end
          else if (nm == NM_DATA_E) begin act_o.line_net = 1'b1; st_d = ST_E; end
          else if (nm == NM_INV) begin act_o.msg_vld = 1'b1; act_o.msg = OM_INV_ACK; st_d = ST_IS_I; end
        end
        ST_IS_I: if (nm == NM_DATA_S || nm == NM_DATA_E) st_d = ST_I;
        ST_IM:   if (nm == NM_DATA_E) begin act_o.line_tbe = 1'b1; st_d = ST_M; end
        ST_SM:   if (nm == NM_ACK) begin act_o.line_tbe = 1'b1; st_d = ST_M; end
        ST_M_I: begin
          if (nm == NM_ACK) st_d = ST_I;
          else if (nm == NM_FWDX || nm == NM_INV) begin
            act_o.msg_vld = 1'b1; act_o.from_tbe = 1'b1; st_d = ST_SINK;
            act_o.msg = (nm == NM_FWDX) ? OM_DATA_REQ : OM_DATA_L2;
          end
        end
        ST_SINK: begin
          if (nm == NM_INV) begin act_o.msg_vld = 1'b1; act_o.msg = OM_INV_ACK; end
          else if (nm == NM_ACK) st_d = ST_I;
        end
        default: st_d = ST_I;
      endcase
    end else if (cpu_valid_i && cpu_ready_o) begin
      unique case (st_q)
        ST_I: begin
          if (op == OP_LOAD || op == OP_IFETCH) begin
            act_o.msg_vld = 1'b1; act_o.msg = OM_GETS; act_o.cap_addr = 1'b1; st_d = ST_IS;
          end else if (op == OP_STORE) begin
            act_o.msg_vld = 1'b1; act_o.msg = OM_GETX; act_o.cap_addr = 1'b1;
            act_o.tbe_wdata = 1'b1; st_d = ST_IM;
          end
        end
        ST_S: begin
          if (op == OP_STORE) begin
            act_o.msg_vld = 1'b1; act_o.msg = OM_GETX; act_o.tbe_wdata = 1'b1; st_d = ST_SM;
          end else if (op == OP_REPL) begin
            act_o.evict = 1'b1; st_d = ST_I;
          end
        end
        ST_E, ST_M: begin
          if (op == OP_STORE) begin
            act_o.line_wdata = 1'b1; st_d = ST_M;
          end else if (op == OP_REPL) begin
            act_o.msg_vld = 1'b1; act_o.msg = OM_PUTX; act_o.tbe_line = 1'b1;
            act_o.evict = 1'b1; st_d = ST_M_I;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/l1c_line_store.sv
module l1c_line_store
  import l1c_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  act_t          act_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic [DW-1:0] net_data_i,
  output logic [AW-1:0] addr_d_o,
  output logic [DW-1:0] line_q_o,
  output logic [DW-1:0] tbe_q_o
);
  logic [AW-1:0] addr_q;

  assign addr_d_o = act_i.cap_addr ? cpu_addr_i : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      line_q_o <= '0;
      tbe_q_o  <= '0;
    end else begin
      addr_q <= addr_d_o;
      if (act_i.line_wdata)    line_q_o <= cpu_wdata_i;
      else if (act_i.line_net) line_q_o <= net_data_i;
      else if (act_i.line_tbe) line_q_o <= tbe_q_o;
      if (act_i.tbe_wdata)     tbe_q_o <= cpu_wdata_i;
      else if (act_i.tbe_line) tbe_q_o <= line_q_o;
    end
  end
endmodule

// File: rtl/l1c_msg_out.sv
module l1c_msg_out
  import l1c_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  act_t          act_i,
  input  logic          evict_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] line_i,
  input  logic [DW-1:0] tbe_i,
  output logic          msg_valid_o,
  output logic [2:0]    msg_type_o,
  output logic [AW-1:0] msg_addr_o,
  output logic [DW-1:0] msg_data_o,
  output logic          evict_valid_o,
  output logic [AW-1:0] evict_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o   <= 1'b0;
      msg_type_o    <= '0;
      msg_addr_o    <= '0;
      msg_data_o    <= '0;
      evict_valid_o <= 1'b0;
      evict_addr_o  <= '0;
    end else begin
      msg_valid_o   <= act_i.msg_vld;
      msg_type_o    <= act_i.msg;
      msg_addr_o    <= addr_i;
      msg_data_o    <= act_i.from_tbe ? tbe_i : line_i;
      evict_valid_o <= act_i.evict && evict_en_i;
      evict_addr_o  <= addr_i;
    end
  end
endmodule

// File: rtl/l1_line_ctrl.sv
module l1_line_ctrl
  import l1c_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evict_en_i,
  input  logic          cpu_valid_i,
  input  logic [1:0]    cpu_op_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_ready_o,
  input  logic          net_valid_i,
  input  logic [2:0]    net_type_i,
  input  logic [DW-1:0] net_data_i,
  output logic          msg_valid_o,
  output logic [2:0]    msg_type_o,
  output logic [AW-1:0] msg_addr_o,
  output logic [DW-1:0] msg_data_o,
  output logic          evict_valid_o,
  output logic [AW-1:0] evict_addr_o
);
  line_st_e      st_q, st_d;
  act_t          act;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] line_q, tbe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_I;
    else         st_q <= st_d;
  end

  l1c_fsm u_fsm (
    .st_q(st_q), .cpu_valid_i(cpu_valid_i), .cpu_op_i(cpu_op_i),
    .net_valid_i(net_valid_i), .net_type_i(net_type_i),
    .st_d(st_d), .cpu_ready_o(cpu_ready_o), .act_o(act)
  );

  l1c_line_store #(.AW(AW), .DW(DW)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .net_data_i(net_data_i),
    .addr_d_o(addr_d), .line_q_o(line_q), .tbe_q_o(tbe_q)
  );

  l1c_msg_out #(.AW(AW), .DW(DW)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .evict_en_i(evict_en_i),
    .addr_i(addr_d), .line_i(line_q), .tbe_i(tbe_q),
    .msg_valid_o(msg_valid_o), .msg_type_o(msg_type_o), .msg_addr_o(msg_addr_o),
    .msg_data_o(msg_data_o), .evict_valid_o(evict_valid_o), .evict_addr_o(evict_addr_o)
  );
endmodule

// File: rtl/l1c_chk.sv
module l1c_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evict_en_i,
  input logic       net_valid_i,
  input logic       cpu_ready_o,
  input logic       msg_valid_o,
  input logic [2:0] msg_type_o,
  input logic       evict_valid_o
);
  // R8
  evict_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> $past(evict_en_i));
  // R8
  evict_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |=> !evict_valid_o);
  // R5
  putx_notify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o == 3'd5 && $past(evict_en_i)) |-> evict_valid_o);
  // R2
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && (msg_type_o == 3'd0 || msg_type_o == 3'd1)) |-> !evict_valid_o);
  // R9
  net_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    net_valid_i |-> !cpu_ready_o);
endmodule

bind l1_line_ctrl l1c_chk u_chk (.*);

// File: tb/l1_line_ctrl_bench.sv
`timescale 1ns/1ps
module l1_line_ctrl_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int P_I = 0, P_S = 1, P_E = 2, P_M = 3, P_IS = 4, P_IM = 5, P_SM = 6,
                 P_ISI = 7, P_MI = 8, P_SK = 9;

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b1;
  logic cv = 1'b0, nv = 1'b0;
  logic [1:0] op = '0;
  logic [2:0] nt = '0;
  logic [AW-1:0] ca = '0;
  logic [DW-1:0] wd = '0, nd = '0;
  logic cpu_ready_o, msg_valid_o, evict_valid_o;
  logic [2:0] msg_type_o;
  logic [AW-1:0] msg_addr_o, evict_addr_o;
  logic [DW-1:0] msg_data_o;

  int n_chk = 0, n_fail = 0;
  int m_st = P_I;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_line = '0, m_tbe = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  l1_line_ctrl u_l1_line_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .evict_en_i(en), .cpu_valid_i(cv), .cpu_op_i(op),
    .cpu_addr_i(ca), .cpu_wdata_i(wd), .cpu_ready_o(cpu_ready_o), .net_valid_i(nv),
    .net_type_i(nt), .net_data_i(nd), .msg_valid_o(msg_valid_o), .msg_type_o(msg_type_o),
    .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o), .evict_valid_o(evict_valid_o),
    .evict_addr_o(evict_addr_o)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, predict, compare registered outputs at next negedge
  task automatic step(input bit c, input bit [1:0] o, input logic [AW-1:0] a,
                      input logic [DW-1:0] w, input bit n, input bit [2:0] t,
                      input logic [DW-1:0] d);
    bit rdy, e_mv, e_ev, e_tbe;
    int e_mt;
    string tag;
    cv = c; op = o; ca = a; wd = w; nv = n; nt = t; nd = d;
    #1;
    rdy = !n && (m_st == P_I || m_st == P_S || m_st == P_E || m_st == P_M);
    check(cpu_ready_o, rdy, "R9 cpu_ready");
    e_mv = 0; e_ev = 0; e_tbe = 0; e_mt = 0; tag = "R9";
    if (n) begin
      if (m_st == P_I && t == 0) begin e_mv = 1; e_mt = 2; tag = "R11"; end
      else if (m_st == P_S && t == 0) begin e_mv = 1; e_mt = 2; e_ev = 1; m_st = P_I; tag = "R4"; end
      else if ((m_st == P_E || m_st == P_M) && t == 0) begin
        e_mv = 1; e_mt = (m_st == P_M) ? 3 : 2; e_ev = 1; m_st = P_I; tag = "R6";
      end else if ((m_st == P_E || m_st == P_M) && t == 1) begin
        e_mv = 1; e_mt = 4; e_ev = 1; m_st = P_I; tag = "R7";
      end else if (m_st == P_IS) begin
        tag = "R3";
        if (t == 2) begin m_line = d; m_st = P_S; end
        else if (t == 3) begin m_line = d; m_st = P_E; end
        else if (t == 0) begin e_mv = 1; e_mt = 2; m_st = P_ISI; tag = "R11"; end
      end else if (m_st == P_ISI) begin
        tag = "R11"; if (t == 2 || t == 3) m_st = P_I;
      end else if (m_st == P_IM && t == 3) begin m_line = m_tbe; m_st = P_M; tag = "R3"; end
      else if (m_st == P_SM && t == 4) begin m_line = m_tbe; m_st = P_M; tag = "R3"; end
      else if (m_st == P_MI) begin
        tag = "R10";
        if (t == 4) m_st = P_I;
        else if (t == 1 || t == 0) begin e_mv = 1; e_mt = (t == 1) ? 4 : 3; e_tbe = 1; m_st = P_SK; end
      end else if (m_st == P_SK) begin
        tag = "R10";
        if (t == 0) begin e_mv = 1; e_mt = 2; end
        else if (t == 4) m_st = P_I;
      end
    end else if (c && rdy) begin
      case (m_st)
        P_I: begin
          tag = "R2";
          if (o != 3) begin
            e_mv = 1; m_addr = a;
            if (o == 2) begin e_mt = 1; m_tbe = w; m_st = P_IM; end
            else begin e_mt = 0; m_st = P_IS; end
          end
        end
        P_S: begin
          if (o == 2) begin e_mv = 1; e_mt = 1; m_tbe = w; m_st = P_SM; tag = "R3"; end
          else if (o == 3) begin e_ev = 1; m_st = P_I; tag = "R4"; end
        end
        default: begin
          tag = "R5";
          if (o == 2) begin m_line = w; m_st = P_M; end
          else if (o == 3) begin e_mv = 1; e_mt = 5; e_ev = 1; m_tbe = m_line; m_st = P_MI; end
        end
      endcase
    end
    @(negedge clk);
    check(msg_valid_o, e_mv, {tag, " msg_valid"});
    if (e_mv) begin
      check(msg_type_o, e_mt, {tag, " msg_type"});
      check(msg_addr_o, m_addr, {tag, " msg_addr"});
      if (e_mt >= 3) check(msg_data_o, e_tbe ? m_tbe : m_line, {tag, " msg_data"});
    end
    check(evict_valid_o, e_ev && en, "R8 evict_valid");
    if (e_ev && en) check(evict_addr_o, m_addr, "R8 evict_addr");
  endtask

  task automatic cpu(input bit [1:0] o, input logic [AW-1:0] a, input logic [DW-1:0] w);
    step(1, o, a, w, 0, 0, '0);
  endtask
  task automatic net(input bit [2:0] t, input logic [DW-1:0] d);
    step(0, 0, '0, '0, 1, t, d);
  endtask

  // fill a line at address a into E (x=3) or S (x=2)
  task automatic fill(input logic [AW-1:0] a, input bit [2:0] x, input logic [DW-1:0] d);
    cpu(0, a, '0);
    net(x, d);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(msg_valid_o, 0, "R1 msg_valid");
    check(evict_valid_o, 0, "R1 evict_valid");
    check(cpu_ready_o, 1, "R1 cpu_ready");
    rst_ni = 1'b1;
    @(negedge clk);
    check(cpu_ready_o, 1, "R1 cpu_ready after release");

    cpu(3, 32'h10, '0);                 // R2 replace in I: no message
    cpu(0, 32'h100, '0);                // R2 GETS
    cpu(0, 32'h100, '0);                // R9 recycled in IS
    net(3, 32'hA1);                     // R3 exclusive fill
    cpu(0, 32'h100, '0);                // hit
    cpu(2, 32'h100, 32'hB1);            // R5 silent E->M
    net(0, '0);                         // R6 DATA_L2 + notify

    cpu(1, 32'h200, '0);                // R2 ifetch miss
    net(2, 32'hA2);                     // R3 shared fill
    cpu(2, 32'h200, 32'hB2);            // R3 upgrade GETX
    cpu(0, 32'h200, '0);                // R9 recycled in SM
    net(4, '0);                         // R3 ack -> M
    cpu(3, 32'h200, '0);                // R5 PUTX + notify
    cpu(0, 32'h200, '0);                // R9 recycled in M_I
    net(4, '0);                         // R10 ack -> I

    fill(32'h300, 2, 32'hA3);
    cpu(3, 32'h300, '0);                // R4 silent replace + notify
    fill(32'h300, 2, 32'hA4);
    net(0, '0);                         // R4 INV_ACK + notify

    cpu(2, 32'h400, 32'hB4);            // R2 store miss
    net(3, 32'hFF);                     // R3 fill to M with store data
    net(1, '0);                         // R7 DATA_REQ

    fill(32'h500, 3, 32'hA5);
    net(1, '0);                         // R7 from E
    fill(32'h500, 3, 32'hA6);
    cpu(3, 32'h500, '0);                // R5 PUTX from E
    net(1, '0);                         // R10 DATA_REQ from buffer
    cpu(0, 32'h500, '0);                // R9 recycled in sink
    net(0, '0);                         // R10 INV_ACK in sink
    net(4, '0);                         // R10 ack -> I

    // R9 R8: replace and INV collide in E
    fill(32'h600, 3, 32'hA7);
    step(1, 3, 32'h600, '0, 1, 0, '0);
    cpu(0, 32'h600, '0);
    net(3, 32'hA8);
    cpu(2, 32'h600, 32'hB8);
    cpu(3, 32'h600, '0);
    step(1, 3, 32'h600, '0, 1, 0, '0); // R10 INV in M_I -> DATA_L2 from buffer
    net(4, '0);

    // R11: INV during read miss
    cpu(0, 32'h700, '0);
    net(0, '0);
    cpu(0, 32'h700, '0);                // recycled in IS_I
    net(2, 32'hA9);
    cpu(0, 32'h700, '0);                // misses again

    // R8: notify gated off
    net(2, 32'hAA);
    en = 1'b0;
    net(0, '0);
    fill(32'h800, 3, 32'hAB);
    cpu(3, 32'h800, '0);
    net(4, '0);
    cpu(2, 32'h900, 32'hBC);
    net(3, '0);
    net(1, '0);
    en = 1'b1;
    fill(32'hA00, 3, 32'hAD);
    net(1, '0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule